// File: doc/BRIEF.md
# Multi-Width Parallel Host Port

This block is the host side of a display controller's register port. A processor reaches it over an asynchronous parallel bus with an active-low chip select, a register-select line, and separate active-low read and write strobes. A static four-bit mode code selects the bus width. The widths are 18, 16 or 9 bits, or 8 bits with the high byte sent first or the low byte sent first. Each width uses its own subset of the 18 data pins, and the 16-bit subset skips pin 9. The port converts between those pins and one internal 18-bit word, so the rest of the controller always sees whole words.

Register select low addresses the index register on a write and the status word on a read. Register select high addresses the data register that the index points at. In the 9-bit and 8-bit modes a data word takes two strobes, and a beat pointer tracks which half comes next. The strobes are synchronised into the core clock. A write takes effect one time, after its strobe rises. Read data goes straight onto the pins and is driven only while the port is selected and the read strobe is low.

The control path is a four-state machine on the synchronised strobes:
- `ST_IDLE` moves to `ST_WRITE` when the port is selected, the write strobe is low and the mode code is valid.
- `ST_IDLE` moves to `ST_READ` when the port is selected and the read strobe is low.
- `ST_WRITE` holds the pins and register select while the strobe stays low.
- `ST_WRITE` moves to `ST_COMMIT` when the strobe rises, or returns to `ST_IDLE` if the chip select is released first.
- `ST_COMMIT` applies the write and returns to `ST_IDLE`.
- `ST_READ` returns to `ST_IDLE` when the read strobe rises or the chip select is released. A data read in a two-beat mode advances the beat pointer on this exit.

Top module: `hostbus_port`

## Requirements
In this list, the "lane" of a mode is the set of data pins that one strobe carries, gathered and right-aligned into a value.
- R1: After reset, all data registers and the index are zero, the bus is not driven, and the beat pointer is at the first beat.
- R2: While `cs_n` is high, both strobes are ignored: no register or index changes and `db_oe` stays 0.
- R3: `db_oe` is 1 only while `cs_n` and `rd_n` are both low and the mode code is valid. Outside that window `db_out` is all zeros.
- R4: With `rs` low, a write loads the index from the low IDX_W bits of the lane, and a read returns the status lane. The status lane holds the mode code in bits [7:4] and the index in bits [3:0], with all other bits zero. With `rs` high, the access goes to the data register selected by the index.
- R5: Mode code 0 is 18-bit: pins 17..0 carry the whole word in one strobe.
- R6: Mode code 1 is 16-bit. Pins 17..10 carry word bits 15..8 and pins 8..1 carry bits 7..0. Pins 9 and 0 are ignored on writes and driven 0 on reads. Word bits 17..16 are written as 0.
- R7: Mode code 2 is 9-bit on pins 17..9, in two strobes. The first strobe carries word bits 17..9 and the second carries bits 8..0. Pins 8..0 are driven 0 on reads.
- R8: Mode code 3 is 8-bit on pins 17..10, in two strobes, high byte (bits 15..8) first. Word bits 17..16 are written as 0 and pins 9..0 are driven 0.
- R9: Mode code 4 is 8-bit on pins 17..10, in two strobes, low byte (bits 7..0) first.
- R10: Releasing the chip select, or writing the index, returns the beat pointer to the first beat. A half-written word is discarded.
- R11: Mode codes 5 to 15 are reserved: no write is taken and the bus is never driven.
- R12: Each write strobe updates its target exactly once, after the strobe rises, however long the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 4 | Static bus mode code |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select: 0 = index/status, 1 = data register |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| db_in | input | 18 | Data pins as seen by the port |
| db_out | output | 18 | Data driven onto the pins during a read |
| db_oe | output | 1 | Output enable for the data pins |

## Verification
The bench sweeps all five valid modes and writes and reads back every register with a distinct value. In 16-bit mode it sets pin 9 and pin 0 to 1 on every write, and it checks that unused pins read back as zero. A wrong pin map would show up as swapped or shifted bits, and a byte-order swap as exchanged halves. The beat pointer is tested by leaving a half word behind and then releasing the chip select or writing the index; a pointer that does not reset would splice the old byte into the next word. A strobe held for dozens of cycles must not advance the pointer twice. A reserved mode code, or a write with the chip select high, must leave the registers unchanged and the bus undriven.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int BUS_W  = 18;
    localparam int PART_W = 9;

    typedef enum logic [2:0] {
        BW_18, BW_16, BW_9, BW_8HI, BW_8LO, BW_NONE
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_WRITE, ST_READ, ST_COMMIT
    } port_state_e;

    function automatic bus_mode_e decode_mode(input logic [3:0] code);
        bus_mode_e m;
        case (code)
            4'd0:    m = BW_18;
            4'd1:    m = BW_16;
            4'd2:    m = BW_9;
            4'd3:    m = BW_8HI;
            4'd4:    m = BW_8LO;
            default: m = BW_NONE;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int           W      = 3,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] INIT   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hb_lane.sv
module hb_lane
    import hb_pkg::*;
(
    input  bus_mode_e          mode,
    input  logic               phase,
    input  logic [BUS_W-1:0]   bus_held,
    input  logic [PART_W-1:0]  pend,
    input  logic [BUS_W-1:0]   rd_word,
    input  logic [BUS_W-1:0]   out_lane,
    output logic [BUS_W-1:0]   in_lane,
    output logic [BUS_W-1:0]   wr_word,
    output logic [BUS_W-1:0]   rd_part,
    output logic [BUS_W-1:0]   bus_drive
);
    // Bus pins -> right-aligned lane for the active width
    always_comb begin
        unique case (mode)
            BW_16:         in_lane = {2'b00, bus_held[17:10], bus_held[8:1]};
            BW_9:          in_lane = {9'd0, bus_held[17:9]};
            BW_8HI, BW_8LO: in_lane = {10'd0, bus_held[17:10]};
            default:       in_lane = bus_held;
        endcase
    end

    // Assemble the full word on the final beat
    always_comb begin
        unique case (mode)
            BW_9:    wr_word = {pend, in_lane[8:0]};
            BW_8HI:  wr_word = {2'b00, pend[7:0], in_lane[7:0]};
            BW_8LO:  wr_word = {2'b00, in_lane[7:0], pend[7:0]};
            default: wr_word = in_lane;
        endcase
    end

    // Pick the portion of the stored word for the current read beat
    always_comb begin
        unique case (mode)
            BW_9:    rd_part = phase ? {9'd0, rd_word[8:0]}   : {9'd0, rd_word[17:9]};
            BW_8HI:  rd_part = phase ? {10'd0, rd_word[7:0]}  : {10'd0, rd_word[15:8]};
            BW_8LO:  rd_part = phase ? {10'd0, rd_word[15:8]} : {10'd0, rd_word[7:0]};
            default: rd_part = rd_word;
        endcase
    end

    // Lane -> bus pins for reads
    always_comb begin
        unique case (mode)
            BW_16:          bus_drive = {out_lane[15:8], 1'b0, out_lane[7:0], 1'b0};
            BW_9:           bus_drive = {out_lane[8:0], 9'd0};
            BW_8HI, BW_8LO: bus_drive = {out_lane[7:0], 10'd0};
            default:        bus_drive = out_lane;
        endcase
    end
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int IDX_W  = 4,
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int NREG = 1 << IDX_W;

    logic [WORD_W-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
    import hb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  mode_sel,
    input  logic        cs_n,
    input  logic        rs,
    input  logic        wr_n,
    input  logic        rd_n,
    input  logic [17:0] db_in,
    output logic [17:0] db_out,
    output logic        db_oe
);
    localparam int STAT_PAD = BUS_W - 4 - IDX_W;

    port_state_e state, state_nx;
    bus_mode_e   mode;
    logic        mode_ok, two_beat;
    logic        cs_s, wr_s, rd_s;
    logic [BUS_W-1:0]  hold_db;
    logic              hold_rs;
    logic [PART_W-1:0] pend;
    logic              phase;
    logic [IDX_W-1:0]  index_r;
    logic [BUS_W-1:0]  in_lane, wr_word, rd_part, bus_drive, rd_word, out_lane;
    logic              commit, idx_we, reg_we, rd_adv;

    assign mode     = decode_mode(mode_sel);
    assign mode_ok  = (mode != BW_NONE);
    assign two_beat = (mode == BW_9) || (mode == BW_8HI) || (mode == BW_8LO);

    hb_sync #(.W(3), .STAGES(2), .INIT(3'b111)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, wr_n, rd_n}),
        .q     ({cs_s, wr_s, rd_s})
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (mode_ok && !cs_s) begin
                    if (!wr_s)      state_nx = ST_WRITE;
                    else if (!rd_s) state_nx = ST_READ;
                end
            end
            ST_WRITE: begin
                if (cs_s)      state_nx = ST_IDLE;
                else if (wr_s) state_nx = ST_COMMIT;
            end
            ST_COMMIT: state_nx = ST_IDLE;
            ST_READ: begin
                if (cs_s || rd_s) state_nx = ST_IDLE;
            end
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        commit = (state == ST_COMMIT);
        idx_we = commit && !hold_rs;
        reg_we = commit && hold_rs && !(two_beat && !phase);
        rd_adv = (state == ST_READ) && rd_s && !cs_s && hold_rs && two_beat;
    end

    // Capture pins and register select while the strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_db <= '0;
            hold_rs <= 1'b0;
        end else if (state_nx == ST_WRITE) begin
            hold_db <= db_in;
            hold_rs <= rs;
        end else if (state_nx == ST_READ && state == ST_IDLE) begin
            hold_rs <= rs;
        end
    end

    // Index, beat pointer and pending half word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_r <= '0;
            phase   <= 1'b0;
            pend    <= '0;
        end else begin
            if (idx_we) index_r <= in_lane[IDX_W-1:0];
            if (commit && hold_rs && two_beat && !phase) pend <= in_lane[PART_W-1:0];
            if (cs_s || idx_we)  phase <= 1'b0;
            else if (commit)     phase <= two_beat && !phase;
            else if (rd_adv)     phase <= !phase;
        end
    end

    hb_lane lane_i (
        .mode      (mode),
        .phase     (phase),
        .bus_held  (hold_db),
        .pend      (pend),
        .rd_word   (rd_word),
        .out_lane  (out_lane),
        .in_lane   (in_lane),
        .wr_word   (wr_word),
        .rd_part   (rd_part),
        .bus_drive (bus_drive)
    );

    hb_regfile #(.IDX_W(IDX_W), .WORD_W(BUS_W)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (index_r),
        .wdata (wr_word),
        .raddr (index_r),
        .rdata (rd_word)
    );

    // Read path straight from the pins
    always_comb begin
        out_lane = rs ? rd_part : {{STAT_PAD{1'b0}}, mode_sel, index_r};
        db_oe    = mode_ok && !cs_n && !rd_n;
        db_out   = db_oe ? bus_drive : '0;
    end

    assert_cs_high_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && state == ST_IDLE) |=> (state == ST_IDLE));

    assert_reserved_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ok && state == ST_IDLE) |=> (state == ST_IDLE));

    assert_cs_clears_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !phase);

    assert_index_clears_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && !hold_rs) |=> !phase);

    assert_single_beat_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && hold_rs && !two_beat) |=> !phase);

    assert_commit_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |-> ($past(state) == ST_WRITE));
endmodule

// File: tb/hostbus_port_tb.sv
`timescale 1ns/1ps
module hostbus_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_sel = 4'd0;
    logic        cs_n = 1'b1, rs = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
    logic [17:0] db_in = '0;
    logic [17:0] db_out;
    logic        db_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    hostbus_port dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .rs(rs),
        .wr_n(wr_n), .rd_n(rd_n), .db_in(db_in), .db_out(db_out), .db_oe(db_oe)
    );

    task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [17:0] lane_to_bus(input int code, input logic [17:0] l);
        if (code == 1)      return {l[15:8], 1'b0, l[7:0], 1'b0};
        else if (code == 2) return {l[8:0], 9'd0};
        else if (code >= 3) return {l[7:0], 10'd0};
        return l;
    endfunction

    function automatic logic [17:0] bus_to_lane(input int code, input logic [17:0] d);
        if (code == 1)      return {2'b00, d[17:10], d[8:1]};
        else if (code == 2) return {9'd0, d[17:9]};
        else if (code >= 3) return {10'd0, d[17:10]};
        return d;
    endfunction

    task automatic strobe_wr(input logic rsv, input logic [17:0] d, input int hold);
        @(negedge clk); rs = rsv; db_in = d; cs_n = 1'b0;
        @(negedge clk); wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic strobe_rd(input logic rsv, output logic [17:0] d, output logic oe);
        @(negedge clk); rs = rsv; cs_n = 1'b0;
        @(negedge clk); rd_n = 1'b0;
        repeat (3) @(negedge clk);
        d = db_out; oe = db_oe;
        rd_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_off();
        @(negedge clk); cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic set_mode(input int code);
        cs_off();
        mode_sel = code[3:0];
        repeat (2) @(negedge clk);
    endtask

    task automatic set_index(input int code, input int idx);
        strobe_wr(1'b0, lane_to_bus(code, 18'(idx)), 4);
    endtask

    task automatic put_word(input int code, input logic [17:0] w);
        if (code == 0) strobe_wr(1'b1, w, 4);
        else if (code == 1) strobe_wr(1'b1, lane_to_bus(1, w) | 18'h00201, 4);
        else if (code == 2) begin
            strobe_wr(1'b1, lane_to_bus(2, {9'd0, w[17:9]}) | 18'h001FF, 4);
            strobe_wr(1'b1, lane_to_bus(2, {9'd0, w[8:0]})  | 18'h001FF, 4);
        end else if (code == 3) begin
            strobe_wr(1'b1, lane_to_bus(3, {10'd0, w[15:8]}) | 18'h003FF, 4);
            strobe_wr(1'b1, lane_to_bus(3, {10'd0, w[7:0]})  | 18'h003FF, 4);
        end else begin
            strobe_wr(1'b1, lane_to_bus(4, {10'd0, w[7:0]})  | 18'h003FF, 4);
            strobe_wr(1'b1, lane_to_bus(4, {10'd0, w[15:8]}) | 18'h003FF, 4);
        end
    endtask

    task automatic get_word(input int code, output logic [17:0] w, output logic pins_ok, output logic oe_ok);
        logic [17:0] d1, d2;
        logic o1, o2;
        strobe_rd(1'b1, d1, o1);
        w = d1; pins_ok = 1'b1; oe_ok = o1;
        if (code == 1) begin
            w = {2'b00, d1[17:10], d1[8:1]};
            pins_ok = (d1[9] == 1'b0) && (d1[0] == 1'b0);
        end else if (code >= 2) begin
            strobe_rd(1'b1, d2, o2);
            oe_ok = o1 & o2;
            if (code == 2) begin
                w = {d1[17:9], d2[17:9]};
                pins_ok = (d1[8:0] == 9'd0) && (d2[8:0] == 9'd0);
            end else begin
                w = (code == 3) ? {2'b00, d1[17:10], d2[17:10]} : {2'b00, d2[17:10], d1[17:10]};
                pins_ok = (d1[9:0] == 10'd0) && (d2[9:0] == 10'd0);
            end
        end
    endtask

    function automatic logic [17:0] pattern(input int code, input int r);
        return 18'((r * 32'h0B5A7) + (code * 32'h1357) + 32'h2A5C3);
    endfunction

    function automatic logic [17:0] mask_for(input int code);
        return (code == 0 || code == 2) ? 18'h3FFFF : 18'h0FFFF;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [17:0] d, w;
        logic oe, pins_ok, oe_ok;
        string tag;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 oe after reset", 18'(db_oe), 18'd0);
        strobe_rd(1'b0, d, oe);
        chk("R1 status after reset", d, 18'd0);
        get_word(0, w, pins_ok, oe_ok);
        chk("R1 reg0 after reset", w, 18'd0);
        set_index(0, 7);
        get_word(0, w, pins_ok, oe_ok);
        chk("R1 reg7 after reset", w, 18'd0);
        chk("R3 oe during read", 18'(oe_ok), 18'd1);
        chk("R3 oe after read", 18'(db_oe), 18'd0);
        chk("R3 data after read", db_out, 18'd0);

        // Sweep all valid modes over every register
        for (int code = 0; code < 5; code++) begin
            if (code == 0)      tag = "R5";
            else if (code == 1) tag = "R6";
            else if (code == 2) tag = "R7";
            else if (code == 3) tag = "R8";
            else                tag = "R9";
            set_mode(code);
            for (int r = 0; r < 16; r++) begin
                set_index(code, r);
                put_word(code, pattern(code, r));
            end
            for (int r = 0; r < 16; r++) begin
                set_index(code, r);
                get_word(code, w, pins_ok, oe_ok);
                chk({tag, " word"}, w, pattern(code, r) & mask_for(code));
                chk({tag, " unused pins"}, 18'(pins_ok), 18'd1);
                chk("R3 oe in read", 18'(oe_ok), 18'd1);
            end
            set_index(code, 9);
            strobe_rd(1'b0, d, oe);
            chk("R4 status lane", bus_to_lane(code, d), {10'd0, code[3:0], 4'd9});
        end

        // R2: chip select high blocks strobes
        set_mode(0);
        set_index(0, 3);
        put_word(0, 18'h12345);
        cs_off();
        @(negedge clk); rs = 1'b1; db_in = 18'h3ABCD; wr_n = 1'b0;
        repeat (5) @(negedge clk); wr_n = 1'b1;
        repeat (5) @(negedge clk); rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 oe with cs high", 18'(db_oe), 18'd0);
        chk("R2 data with cs high", db_out, 18'd0);
        rd_n = 1'b1;
        repeat (5) @(negedge clk);
        set_index(0, 3);
        get_word(0, w, pins_ok, oe_ok);
        chk("R2 reg unchanged", w, 18'h12345);

        // R10: cs release discards a half word
        set_mode(3);
        set_index(3, 5);
        strobe_wr(1'b1, lane_to_bus(3, 18'h000AA), 4);
        cs_off();
        put_word(3, 18'h01234);
        set_index(3, 5);
        get_word(3, w, pins_ok, oe_ok);
        chk("R10 cs release restarts", w, 18'h01234);

        // R10: index write discards a half word
        set_index(3, 6);
        strobe_wr(1'b1, lane_to_bus(3, 18'h00055), 4);
        set_index(3, 6);
        put_word(3, 18'h09876);
        set_index(3, 6);
        get_word(3, w, pins_ok, oe_ok);
        chk("R10 index write restarts", w, 18'h09876);

        // R12: a long strobe commits once
        set_mode(4);
        set_index(4, 2);
        strobe_wr(1'b1, lane_to_bus(4, 18'h0003C), 40);
        strobe_wr(1'b1, lane_to_bus(4, 18'h000C3), 4);
        set_index(4, 2);
        get_word(4, w, pins_ok, oe_ok);
        chk("R12 long strobe single beat", w, 18'h0C33C);

        // R4: index selects the register
        set_index(4, 3);
        get_word(4, w, pins_ok, oe_ok);
        chk("R4 index routes data", w, 18'h02345);

        // R11: reserved codes
        set_mode(0);
        set_index(0, 1);
        put_word(0, 18'h0F0F0);
        for (int code = 5; code < 16; code += 5) begin
            set_mode(code);
            strobe_wr(1'b0, 18'd4, 4);
            strobe_wr(1'b1, 18'h3FFFF, 4);
            strobe_rd(1'b1, d, oe);
            chk("R11 no drive", 18'(oe), 18'd0);
            chk("R11 zero data", d, 18'd0);
        end
        set_mode(0);
        strobe_rd(1'b0, d, oe);
        chk("R11 index kept", d, 18'd1);
        get_word(0, w, pins_ok, oe_ok);
        chk("R11 reg kept", w, 18'h0F0F0);

        cs_off();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule